// File: doc/BRIEF.md
# Matrix Sum of Absolute Differences Engine

This block takes two 4x4 matrices of 8-bit unsigned values and returns one number: the total of the absolute differences between matching positions. Both matrices arrive as flat vectors together with a one-cycle `start` strobe. The block copies them into operand registers in that cycle. It then works through the sixteen positions in a fixed number of clock cycles, and finally presents the total with a one-cycle `res_valid` pulse.

The parameter `CYCLES` sets how long one job takes: 1, 2, 4 or 16 clocks. In each cycle, `16 / CYCLES` absolute-difference units run side by side. A widening adder combines their outputs, and an accumulator gathers the partial totals over the cycles of the job. A new job may begin in the same cycle that delivers the previous result, so the block can take one job every `CYCLES` clocks.

Top module: `mat_sad`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `res_valid` are 0 and `result` is 0.
- R2: Entry k of a matrix (k = 0..15) occupies bits [8k+7:8k] of its input vector. The result equals the sum over all k of |a_k - b_k|, with both entries treated as unsigned, whichever of the two is larger.
- R3: `result` is 12 bits wide and holds the largest possible total, 4080, without wrapping. This total occurs when one matrix is all 255 and the other is all 0, in either order.
- R4: A start is accepted when `start` is 1 at a rising edge while the block is idle. For an accepted start, `res_valid` becomes 1 after exactly `CYCLES` further rising edges and is 0 before that. When `CYCLES` > 1, it stays high for a single cycle.
- R5: `busy` is 1 from the edge that accepts a start until the edge that delivers the result. A `start` seen during any earlier busy cycle is ignored: it produces no extra result and does not alter the running job.
- R6: The operands are captured at the accepting edge. Later changes on `a_in` or `b_in` do not affect that job's result.
- R7: A `start` present in the final busy cycle is accepted at the same edge that delivers the current result. `busy` then stays 1, the delivered result belongs to the old operands, and the new job's result follows `CYCLES` edges later.
- R8: `result` keeps its value in every cycle in which `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a computation on the present operands |
| a_in | input | 128 | First matrix, entry k in bits [8k+7:8k] |
| b_in | input | 128 | Second matrix, same layout |
| busy | output | 1 | A job is in progress |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 12 | Sum of absolute differences |

## Verification
Two functions can fall in the same cycle: delivering a finished total and accepting the next pair of matrices. The bench provokes this by holding `start` high with fresh operands during the last busy cycle. It then judges three things. The pulse must carry the old total, `busy` must stay high, and the second total must appear exactly `CYCLES` edges later, computed only from the new operands, which shows that the accumulator was cleared. A start placed earlier in a job is also driven, to confirm that only the final busy cycle accepts one.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // Width of a sum of n values of w bits each, wide enough that it never overflows
  function automatic int sum_width(input int w, input int n);
    return w + $clog2(n);
  endfunction

  // Number of bits needed to count the steps of one job
  function automatic int step_width(input int cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] d
);
  always_comb begin
    if (x >= y) d = x - y;
    else        d = y - x;
  end
endmodule

// File: rtl/sad_lane_adder.sv
module sad_lane_adder #(
  parameter int W  = 8,
  parameter int N  = 4,
  parameter int OW = W + $clog2(N)
) (
  input  logic [N*W-1:0] vals,
  output logic [OW-1:0]  sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + OW'(vals[i*W +: W]);
    end
  end
endmodule

// File: rtl/sad_seq.sv
module sad_seq
  import sad_pkg::*;
#(
  parameter int CYCLES = 4,
  localparam int STEP_W = step_width(CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              accept,
  output logic              last,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  assign last   = busy && (step == STEP_W'(CYCLES - 1));
  assign accept = start && (!busy || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (last) begin
      busy <= 1'b0;
      step <= '0;
    end else if (busy) begin
      step <= step + STEP_W'(1);
    end
  end
endmodule

// File: rtl/mat_sad.sv
module mat_sad
  import sad_pkg::*;
#(
  parameter int ELEM_W = 8,
  parameter int ELEMS  = 16,
  parameter int CYCLES = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [ELEMS*ELEM_W-1:0]             a_in,
  input  logic [ELEMS*ELEM_W-1:0]             b_in,
  output logic                                busy,
  output logic                                res_valid,
  output logic [ELEM_W+$clog2(ELEMS)-1:0]     result
);
  localparam int LANES  = ELEMS / CYCLES;
  localparam int VEC_W  = ELEMS * ELEM_W;
  localparam int RES_W  = sum_width(ELEM_W, ELEMS);
  localparam int LSUM_W = sum_width(ELEM_W, LANES);
  localparam int STEP_W = step_width(CYCLES);

  logic              accept;
  logic              last_step;
  logic [STEP_W-1:0] step;
  logic [VEC_W-1:0]  a_q, b_q;
  logic [LANES*ELEM_W-1:0] diff_vec;
  logic [LSUM_W-1:0] lane_sum;
  logic [RES_W-1:0]  acc;

  sad_seq #(.CYCLES(CYCLES)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .last   (last_step),
    .busy   (busy),
    .step   (step)
  );

  // Operand capture at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_in;
      b_q <= b_in;
    end
  end

  // One difference unit per lane; lane j handles position step*LANES + j
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] a_sel, b_sel, d;
    always_comb begin
      int pos;
      pos   = int'(step) * LANES + j;
      a_sel = a_q[pos*ELEM_W +: ELEM_W];
      b_sel = b_q[pos*ELEM_W +: ELEM_W];
    end
    sad_absdiff #(.W(ELEM_W)) u_abs (
      .x (a_sel),
      .y (b_sel),
      .d (d)
    );
    assign diff_vec[j*ELEM_W +: ELEM_W] = d;
  end

  sad_lane_adder #(.W(ELEM_W), .N(LANES), .OW(LSUM_W)) u_add (
    .vals (diff_vec),
    .sum  (lane_sum)
  );

  // Accumulation and registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= last_step;
      if (last_step) result <= acc + RES_W'(lane_sum);
      if (accept || last_step) acc <= '0;
      else if (busy)           acc <= acc + RES_W'(lane_sum);
    end
  end
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
  parameter int CYCLES = 4,
  parameter int RES_W  = 12,
  parameter int MAXSUM = 4080
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             last,
  input logic             res_valid,
  input logic [RES_W-1:0] result
);
  localparam int CW = $clog2(CYCLES + 2);
  logic [CW-1:0] cnt;

  // Edges since the most recent accepted start
  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (start && (!busy || last)) cnt <= CW'(1);
    else if (busy)                     cnt <= cnt + CW'(1);
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(cnt) == CW'(CYCLES)));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (CYCLES > 1 && res_valid) |=> !res_valid);

  p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_busy_before_valid_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(busy));

  p_back_to_back_r7: assert property (@(posedge clk) disable iff (rst)
    (start && last) |=> (busy && res_valid));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(result));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (result <= RES_W'(MAXSUM)));
endmodule

bind mat_sad sad_checker #(
  .CYCLES (CYCLES),
  .RES_W  (ELEM_W + $clog2(ELEMS)),
  .MAXSUM (ELEMS * ((1 << ELEM_W) - 1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .last      (last_step),
  .res_valid (res_valid),
  .result    (result)
);

// File: tb/sim_mat_sad.sv
module sim_mat_sad;
  localparam int LAT = 4;
  localparam int NB  = 128;
  localparam int RW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [NB-1:0] a_in = '0, b_in = '0;
  logic          busy, res_valid;
  logic [RW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mat_sad #(.ELEM_W(8), .ELEMS(16), .CYCLES(LAT)) u0 (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .res_valid(res_valid), .result(result)
  );

  function automatic logic [RW-1:0] ref_sad(input logic [NB-1:0] a, b);
    int s = 0;
    for (int k = 0; k < 16; k++) begin
      int x = int'(a[k*8 +: 8]);
      int y = int'(b[k*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return RW'(s);
  endfunction

  function automatic logic [NB-1:0] pat(input int mul, input int off);
    logic [NB-1:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'((k * mul + off) & 255);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive a start; returns at the falling edge after the accepting edge
  task automatic fire(input logic [NB-1:0] a, input logic [NB-1:0] b);
    @(negedge clk);
    a_in = a; b_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Walk LAT edges and judge valid timing, busy and value
  task automatic expect_result(input logic [RW-1:0] exp, input string req);
    bit early_ok = 1'b1;
    for (int k = 1; k <= LAT; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < LAT && (res_valid || !busy)) early_ok = 1'b0;
    end
    chk(early_ok, {req, " R4 R5 no early valid, busy held"}, int'(early_ok), 1);
    chk(res_valid == 1'b1, {req, " R4 valid at latency"}, int'(res_valid), 1);
    chk(result == exp, {req, " result"}, int'(result), int'(exp));
    @(posedge clk);
    @(negedge clk);
    if (LAT > 1) chk(res_valid == 1'b0, {req, " R4 single pulse"}, int'(res_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !res_valid && result == '0, "R1 reset state",
        int'({busy, res_valid}) + int'(result), 0);
  endtask

  task automatic t_values();
    logic [NB-1:0] pa = pat(16, 3), pb = pat(-9, 200);
    fire('0, '0);           expect_result(12'd0, "R2 zeros");
    fire(pa, pb);           expect_result(ref_sad(pa, pb), "R2 mixed order");
    fire(pb, pa);           expect_result(ref_sad(pb, pa), "R2 swapped");
    fire(pat(37, 11), pat(5, 90)); expect_result(ref_sad(pat(37, 11), pat(5, 90)), "R2 pattern3");
  endtask

  task automatic t_max();
    fire({NB{1'b1}}, '0);   expect_result(12'd4080, "R3 max a>b");
    fire('0, {NB{1'b1}});   expect_result(12'd4080, "R3 max b>a");
  endtask

  task automatic t_capture();
    logic [NB-1:0] p1 = pat(7, 1), p2 = pat(3, 250);
    fire(p1, p2);
    a_in = pat(0, 255); b_in = '0;   // changed while busy
    expect_result(ref_sad(p1, p2), "R6 capture");
  endtask

  task automatic t_ignore();
    logic [NB-1:0] p1 = pat(11, 40), p2 = pat(2, 60);
    bit extra = 1'b0;
    fire(p1, p2);
    if (LAT > 1) begin
      a_in = {NB{1'b1}}; b_in = '0; start = 1'b1;   // start mid-job
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      for (int k = 2; k <= LAT; k++) begin @(posedge clk); @(negedge clk); end
    end else begin
      @(posedge clk); @(negedge clk);
    end
    chk(res_valid && result == ref_sad(p1, p2), "R5 ignored start, original result",
        int'(result), int'(ref_sad(p1, p2)));
    for (int k = 0; k < LAT + 2; k++) begin
      @(posedge clk); @(negedge clk);
      if (res_valid || busy) extra = 1'b1;
    end
    chk(!extra, "R5 no extra job after ignored start", int'(extra), 0);
  endtask

  task automatic t_back_to_back();
    logic [NB-1:0] s1a = pat(19, 5), s1b = pat(4, 130);
    logic [NB-1:0] s2a = pat(250, 7), s2b = pat(13, 0);
    fire(s1a, s1b);
    a_in = s2a; b_in = s2b;
    for (int k = 1; k < LAT; k++) begin @(posedge clk); @(negedge clk); end
    start = 1'b1;                      // final busy cycle
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(res_valid && result == ref_sad(s1a, s1b), "R7 old result delivered",
        int'(result), int'(ref_sad(s1a, s1b)));
    chk(busy == 1'b1, "R7 busy kept for new job", int'(busy), 1);
    a_in = '0; b_in = '0;
    expect_result(ref_sad(s2a, s2b), "R7 new job");
  endtask

  task automatic t_hold();
    logic [RW-1:0] held = result;
    bit moved = 1'b0;
    for (int k = 0; k < 6; k++) begin
      a_in = pat(k, 9); b_in = pat(k + 3, 1);
      @(posedge clk); @(negedge clk);
      if (result != held) moved = 1'b1;
    end
    chk(!moved, "R8 result held while idle", int'(result), int'(held));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_values();
    t_max();
    t_capture();
    t_ignore();
    t_back_to_back();
    t_hold();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule